// File: doc/BRIEF.md
# FM Sound Chip Interval Timer Pair

This block holds the two interval timers of an FM sound generator. A shared prescaler divides the master-cycle enable into timer periods of 144 master cycles. The fast timer (10-bit) steps once per period. The slow timer (8-bit) steps once every sixteenth period. Each timer counts down from a software-loaded reload value. When it reloads it can raise a sticky overflow flag, and either flag drives an interrupt line.

The host writes four byte registers through a single write port: the fast-timer reload high byte, its two low bits, the slow-timer reload, and a control byte. Every write raises a busy indication that drops by itself after a fixed number of master cycles. Status is returned as one byte.

Top module: `fm_timer_pair`

## Requirements
- R1: While and after an active-low reset, `statusOut` is 0x00 and `irq` is 0.
- R2: A period starts on every cycEn pulse that finds the prescaler at zero. The first cycEn pulse after reset is a period start, and further starts follow every 144 cycEn pulses. Cycles without cycEn do not advance the prescaler.
- R3: The slow timer steps only on period starts whose index, counted from 0 after reset, is a multiple of 16. That is once per 2304 cycEn pulses.
- R4: The fast timer reload value is the address-0 byte shifted left by two, ORed with bits 1:0 of the address-1 byte. The slow timer reload value is the whole address-2 byte.
- R5: On a step of an enabled timer, a nonzero count decrements by one and a zero count loads the reload value. A disabled timer keeps its count. Counts are zero after reset.
- R6: At a reload, the timer's flag is set only if its flag-enable control bit is 1. The fast timer uses bit 2 and the slow timer uses bit 3.
- R7: Control bit 0 enables the fast timer and bit 1 enables the slow timer. `statusOut` bit 0 is the fast-timer flag, bit 1 is the slow-timer flag, and bits 6:2 read 0.
- R8: Any write sets `statusOut` bit 7 (busy) from the next cycle. Busy clears once 17 cycEn pulses have passed after the write; another write restarts the count.
- R9: A control write with bit 4 set clears the fast flag, and with bit 5 set clears the slow flag. If a flag is set in the same cycle as its clear, the set wins.
- R10: Flags stay set until cleared by R9. `irq` is 1 exactly while either flag is 1.
- R11: Register writes take effect at the clock edge where `wrEn` is high. A step in that same cycle uses the old register values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cycEn | input | 1 | One master cycle elapses in this clock |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register select: 0 fast high, 1 fast low, 2 slow, 3 control |
| wrData | input | 8 | Write data |
| statusOut | output | 8 | {busy, 5'b0, slow flag, fast flag} |
| irq | output | 1 | Interrupt request, high while any flag is set |

## Verification
The assertions take for granted that `cycEn`, `wrEn`, `wrAddr` and `wrData` are known values at every clock edge once reset is released. They also assume that a write and a master-cycle pulse may coincide, with the write dominating the busy count. The stimulus drives every input from the falling edge with defined values. It mixes back-to-back and sparse cycEn pulses, writes that land on period starts, and control writes that clear a flag in the very cycle it is being set. This keeps every case inside those assumptions while still reaching the collisions.

// File: rtl/fm_timer_pkg.sv
package fm_timer_pkg;

  typedef struct packed {
    logic tickA;
    logic tickB;
    logic clrA;
    logic clrB;
  } timerStrobe_t;

  typedef enum logic [1:0] {
    SEL_FAST_HI = 2'd0,
    SEL_FAST_LO = 2'd1,
    SEL_SLOW    = 2'd2,
    SEL_CTRL    = 2'd3
  } regSel_t;

  localparam int CtlEnFast  = 0;
  localparam int CtlEnSlow  = 1;
  localparam int CtlFeFast  = 2;
  localparam int CtlFeSlow  = 3;
  localparam int CtlClrFast = 4;
  localparam int CtlClrSlow = 5;
  localparam int CtlBits    = 4;

endpackage

// File: rtl/fm_timer_ctrl.sv
module fm_timer_ctrl
  import fm_timer_pkg::*;
#(
  parameter int PRESCALE    = 144,
  parameter int SUBDIV      = 16,
  parameter int BUSY_CYCLES = 17,
  parameter int DATA_W      = 8,
  parameter int FAST_LO_W   = 2,
  localparam int FAST_W     = DATA_W + FAST_LO_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cycEn,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output timerStrobe_t      strobe,
  output logic [FAST_W-1:0] reloadFast,
  output logic [DATA_W-1:0] reloadSlow,
  output logic              enFast,
  output logic              enSlow,
  output logic              feFast,
  output logic              feSlow,
  output logic              busy
);

  localparam int PRE_W  = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam int SUB_W  = (SUBDIV > 1) ? $clog2(SUBDIV) : 1;
  localparam int BUSY_W = $clog2(BUSY_CYCLES + 1);

  logic [PRE_W-1:0]     preCnt;
  logic [SUB_W-1:0]     subCnt;
  logic [BUSY_W-1:0]    busyCnt;
  logic [DATA_W-1:0]    fastHi;
  logic [FAST_LO_W-1:0] fastLo;
  logic [DATA_W-1:0]    slowReg;
  logic [CtlBits-1:0]   ctlReg;
  logic                 periodStart;
  logic                 ctlWrite;

  assign periodStart = cycEn && (preCnt == '0);
  assign ctlWrite    = wrEn && (regSel_t'(wrAddr) == SEL_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      preCnt <= '0;
    end else if (cycEn) begin
      preCnt <= (preCnt == PRE_W'(PRESCALE - 1)) ? '0 : preCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      subCnt <= '0;
    end else if (periodStart) begin
      subCnt <= (subCnt == SUB_W'(SUBDIV - 1)) ? '0 : subCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busyCnt <= '0;
    end else if (wrEn) begin
      busyCnt <= BUSY_W'(BUSY_CYCLES);
    end else if (cycEn && busyCnt != '0) begin
      busyCnt <= busyCnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fastHi  <= '0;
      fastLo  <= '0;
      slowReg <= '0;
      ctlReg  <= '0;
    end else if (wrEn) begin
      case (regSel_t'(wrAddr))
        SEL_FAST_HI: fastHi  <= wrData;
        SEL_FAST_LO: fastLo  <= wrData[FAST_LO_W-1:0];
        SEL_SLOW:    slowReg <= wrData;
        default:     ctlReg  <= wrData[CtlBits-1:0];
      endcase
    end
  end

  always_comb begin
    strobe.tickA = periodStart;
    strobe.tickB = periodStart && (subCnt == '0);
    strobe.clrA  = ctlWrite && wrData[CtlClrFast];
    strobe.clrB  = ctlWrite && wrData[CtlClrSlow];
  end

  assign reloadFast = {fastHi, fastLo};
  assign reloadSlow = slowReg;
  assign enFast     = ctlReg[CtlEnFast];
  assign enSlow     = ctlReg[CtlEnSlow];
  assign feFast     = ctlReg[CtlFeFast];
  assign feSlow     = ctlReg[CtlFeSlow];
  assign busy       = (busyCnt != '0);

  // R8
  busy_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrEn |=> busy);

  // R8
  busy_drop_on_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(cycEn) && !$past(wrEn)));

  // R2
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.tickA && PRESCALE > 1) |=> !strobe.tickA);

endmodule

// File: rtl/fm_down_timer.sv
module fm_down_timer #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             en,
  input  logic             flagEn,
  input  logic             clr,
  input  logic [CNT_W-1:0] reload,
  output logic             flag
);

  logic [CNT_W-1:0] cnt;
  logic             step;
  logic             wrap;

  assign step = tick && en;
  assign wrap = step && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (step) begin
      cnt <= (cnt == '0) ? reload : cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
    end else if (wrap && flagEn) begin
      flag <= 1'b1;
    end else if (clr) begin
      flag <= 1'b0;
    end
  end

  // R5
  count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cnt != '0) |=> (cnt == CNT_W'($past(cnt) - 1'b1)));

  // R5
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(cnt));

  // R6
  flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(wrap && flagEn));

  // R10
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past(clr));

endmodule

// File: rtl/fm_timer_pair.sv
module fm_timer_pair
  import fm_timer_pkg::*;
#(
  parameter int PRESCALE    = 144,
  parameter int SUBDIV      = 16,
  parameter int BUSY_CYCLES = 17,
  parameter int DATA_W      = 8,
  parameter int FAST_LO_W   = 2,
  parameter bit USE_IRQ     = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cycEn,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] statusOut,
  output logic              irq
);

  localparam int FAST_W = DATA_W + FAST_LO_W;

  timerStrobe_t      strobe;
  logic [FAST_W-1:0] reloadFast;
  logic [DATA_W-1:0] reloadSlow;
  logic              enFast, enSlow, feFast, feSlow, busy;
  logic              flagFast, flagSlow;

  fm_timer_ctrl #(
    .PRESCALE(PRESCALE), .SUBDIV(SUBDIV), .BUSY_CYCLES(BUSY_CYCLES),
    .DATA_W(DATA_W), .FAST_LO_W(FAST_LO_W)
  ) uCtrl (
    .clk(clk), .rst_n(rst_n), .cycEn(cycEn), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .strobe(strobe),
    .reloadFast(reloadFast), .reloadSlow(reloadSlow),
    .enFast(enFast), .enSlow(enSlow), .feFast(feFast), .feSlow(feSlow),
    .busy(busy)
  );

  fm_down_timer #(.CNT_W(FAST_W)) uFast (
    .clk(clk), .rst_n(rst_n), .tick(strobe.tickA), .en(enFast),
    .flagEn(feFast), .clr(strobe.clrA), .reload(reloadFast), .flag(flagFast)
  );

  fm_down_timer #(.CNT_W(DATA_W)) uSlow (
    .clk(clk), .rst_n(rst_n), .tick(strobe.tickB), .en(enSlow),
    .flagEn(feSlow), .clr(strobe.clrB), .reload(reloadSlow), .flag(flagSlow)
  );

  always_comb begin
    statusOut    = '0;
    statusOut[0] = flagFast;
    statusOut[1] = flagSlow;
    statusOut[DATA_W-1] = busy;
  end

  generate
    if (USE_IRQ) begin : gIrq
      assign irq = flagFast | flagSlow;
    end else begin : gNoIrq
      assign irq = 1'b0;
    end
  endgenerate

  // R3
  slow_on_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.tickB |-> strobe.tickA);

endmodule

// File: tb/sim_fm_timer_pair.sv
module sim_fm_timer_pair;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cycEn = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] statusOut;
  logic       irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string tag = "R1";

  // reference state
  int         mPre, mSub, mBusy, mCntA, mCntB;
  logic [7:0] mHi, mSlow;
  logic [1:0] mLo;
  logic [3:0] mCtl;
  bit         mFlagA, mFlagB;

  always #4 clk = ~clk;

  fm_timer_pair u0 (
    .clk(clk), .rst_n(rst_n), .cycEn(cycEn), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .statusOut(statusOut), .irq(irq)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cycles, act, exp);
    end
  endtask

  task automatic modelReset();
    mPre = 0; mSub = 0; mBusy = 0; mCntA = 0; mCntB = 0;
    mHi = 0; mLo = 0; mSlow = 0; mCtl = 0; mFlagA = 0; mFlagB = 0;
  endtask

  task automatic modelStep(input bit ce, input bit we, input logic [1:0] ad, input logic [7:0] d);
    bit ps, tb, setA, setB, clrA, clrB;
    ps = ce && (mPre == 0);
    tb = ps && (mSub == 0);
    setA = 0; setB = 0;
    if (ps && mCtl[0]) begin
      if (mCntA == 0) begin mCntA = {mHi, mLo}; setA = mCtl[2]; end
      else mCntA = mCntA - 1;
    end
    if (tb && mCtl[1]) begin
      if (mCntB == 0) begin mCntB = mSlow; setB = mCtl[3]; end
      else mCntB = mCntB - 1;
    end
    clrA = we && ad == 2'd3 && d[4];
    clrB = we && ad == 2'd3 && d[5];
    mFlagA = setA ? 1'b1 : (clrA ? 1'b0 : mFlagA);
    mFlagB = setB ? 1'b1 : (clrB ? 1'b0 : mFlagB);
    if (ce) mPre = (mPre == 143) ? 0 : mPre + 1;
    if (ps) mSub = (mSub == 15) ? 0 : mSub + 1;
    if (we) mBusy = 17;
    else if (ce && mBusy != 0) mBusy = mBusy - 1;
    if (we) begin
      case (ad)
        2'd0: mHi = d;
        2'd1: mLo = d[1:0];
        2'd2: mSlow = d;
        default: mCtl = d[3:0];
      endcase
    end
  endtask

  // compare outputs (state after last edge), then drive the next cycle
  task automatic step(input bit ce, input bit we, input logic [1:0] ad, input logic [7:0] d);
    @(negedge clk);
    chk(tag, int'(statusOut[0]), int'(mFlagA));
    chk(tag == "R6" ? "R6" : "R3", int'(statusOut[1]), int'(mFlagB));
    chk("R8", int'(statusOut[7]), int'(mBusy != 0));
    chk("R7", int'(statusOut[6:2]), 0);
    chk("R10", int'(irq), int'(mFlagA | mFlagB));
    cycEn = ce; wrEn = we; wrAddr = ad; wrData = d;
    modelStep(ce, we, ad, d);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, 2'd0, 8'd0);
  endtask

  task automatic wr(input logic [1:0] ad, input logic [7:0] d);
    step(1'b1, 1'b1, ad, d);
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    modelReset();
    repeat (3) @(negedge clk);
    tag = "R1";
    chk("R1", int'(statusOut), 0);
    chk("R1", int'(irq), 0);
    rst_n = 1'b1;

    // R4/R5: fast reload {hi,lo}; first period start reloads from zero
    tag = "R4";
    wr(2'd0, 8'h00);
    wr(2'd1, 8'hFD);           // low bits = 01 -> reload 1
    wr(2'd3, 8'h05);           // enable fast, flag enable fast
    idle(1000);
    wr(2'd0, 8'h01);           // reload 6
    wr(2'd1, 8'h02);
    wr(2'd3, 8'h15);           // clear fast flag
    idle(2500);

    // R9: clear collides with setting event
    tag = "R9";
    wr(2'd0, 8'h00); wr(2'd1, 8'h00);   // reload 0: reload every period
    for (int k = 0; k < 6; k++) begin
      idle(130 + k * 3);
      wr(2'd3, 8'h15);
    end
    idle(300);

    // R5: disabling holds count
    tag = "R5";
    wr(2'd0, 8'h00); wr(2'd1, 8'h03);
    wr(2'd3, 8'h14);           // disabled, flag enable on, clear
    idle(700);
    wr(2'd3, 8'h05);
    idle(900);

    // R6: flag enable off, reloads do not set
    tag = "R6";
    wr(2'd3, 8'h31);           // enable fast only, clear both
    idle(1200);

    // R2: sparse cycEn
    tag = "R2";
    wr(2'd3, 8'h15);
    for (int i = 0; i < 3000; i++) step(($urandom % 3) == 0, 1'b0, 2'd0, 8'd0);

    // R3: slow timer
    tag = "R3";
    wr(2'd2, 8'h01);
    wr(2'd3, 8'h3A);           // enable slow, flag enable slow, clear
    idle(12000);
    wr(2'd3, 8'h2A);
    idle(3000);

    // R11 / R7 / R10: random mix
    tag = "R11";
    for (int i = 0; i < 60000; i++) begin
      bit ce, we;
      logic [1:0] ad;
      logic [7:0] d;
      ce = ($urandom % 4) != 0;
      we = ($urandom % 48) == 0;
      ad = 2'($urandom);
      d  = 8'($urandom);
      if (ad == 2'd0) d = d & 8'h03;
      step(ce, we, ad, d);
    end

    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule